// File: doc/BRIEF.md
# V5 Path Overhead Alarm Monitor

This block supervises the V5 overhead byte of a single low-order tributary. Once per multiframe an upstream framer presents the received V5 byte with a one-cycle valid strobe. From that stream the block derives four path alarm levels: remote defect, remote failure, signal label mismatch and unequipped. It also counts remote error indications in a wrapping counter. The defect, mismatch and unequipped alarms pass through a persistence filter, so they only change after a run of agreeing frames.

Every alarm change and every counter wrap is latched into a sticky status bit. Software clears a status bit by writing 1 to it. A per-source enable register selects which sticky bits drive the single interrupt line. A small register port provides the enables, the sticky status and a read-only copy of the alarm levels. Locating V5 in the frame, parity checking and pointer work are done elsewhere.

Each persistence filter is a four-state machine. IDLE means the alarm is off and no run is in progress. ARMING means the alarm is off and a run of frames meeting the condition is being counted. ACTIVE means the alarm is on and no run is in progress. DISARM means the alarm is on and a run of frames failing the condition is being counted. The transitions are:
- IDLE goes to ARMING on a qualifying frame.
- ARMING goes to ACTIVE on the fifth consecutive qualifying frame. It goes back to IDLE on any frame that does not qualify.
- ACTIVE goes to DISARM on a frame that does not qualify.
- DISARM goes to IDLE on the fifth consecutive frame that does not qualify. It goes back to ACTIVE on any qualifying frame.

Frames that arrive without the strobe never move a filter.

Top module: `v5_alarm_mon`

## Requirements
- R1: After reset, all alarm outputs, `rei_count`, `rei_ovf`, `irq`, the enable register and the status register are 0. The V5 bit layout is as follows:
  - bit 7:6 is parity;
  - bit 5 is REI;
  - bit 4 is RFI;
  - bits 3:1 are the signal label;
  - bit 0 is RDI.
- R2: `alm_rdi` rises on the edge that accepts the fifth consecutive valid byte with bit 0 = 1. A shorter run that is broken by a 0 leaves it low.
- R3: `alm_rdi` falls on the edge that accepts the fifth consecutive valid byte with bit 0 = 0. A shorter run leaves it high.
- R4: `alm_rfi` takes the value of bit 4 of each valid byte on the edge that accepts it.
- R5: `alm_slm` rises after five consecutive valid bytes whose label is outside {000, 001, 010}.
- R6: `alm_slm` falls after five consecutive valid bytes whose label is one of 000, 001 or 010.
- R7: `alm_uneq` rises after five consecutive valid bytes with label 000. It falls after five consecutive valid bytes with a non-zero label.
- R8: `rei_count` increments by one on each valid byte with bit 5 = 1, and holds otherwise.
- R9: A valid REI byte seen while `rei_count` is all ones sets the count to 0. On that edge it also sets status bit 4, and `rei_ovf` is high for the following cycle. Counting then goes on from 0.
- R10: The status register is at address 1. Its bits are:
  - bit 0: UNEQ change;
  - bit 1: SLM change;
  - bit 2: RFI change;
  - bit 3: RDI change;
  - bit 4: REI wrap.
  Each bit is set on the edge where its source changes. Writing 1 to a bit clears it, but a set on the same edge wins over the clear. Address 2 reads the levels with RDI in bit 3, RFI in bit 2, SLM in bit 1 and UNEQ in bit 0. Address 3 reads 0. Writes to address 2 or 3 have no effect.
- R11: The enable register is at address 0, bits 4:0, with the same bit order as the status register. `irq` is the OR over all sources of status AND enable.
- R12: While `v5_valid` is low, the alarms, the count and the status bits hold, whatever `v5_byte` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| v5_valid | input | 1 | One-cycle strobe per multiframe |
| v5_byte | input | 8 | Received V5 byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| alm_rdi | output | 1 | Filtered remote defect alarm |
| alm_rfi | output | 1 | Remote failure alarm |
| alm_slm | output | 1 | Filtered signal label mismatch alarm |
| alm_uneq | output | 1 | Filtered unequipped alarm |
| rei_count | output | CNT_W (16) | Remote error indication count |
| rei_ovf | output | 1 | One-cycle pulse after the counter wraps |
| irq | output | 1 | Combined masked interrupt |

## Verification
The RDI filter is first given a run of four ones broken by a zero, which must not raise it, and then an unbroken run of five, which must. The same pattern is applied on the clearing side, so an off-by-one in either direction of the persistence filter shows up. Label patterns move from an accepted non-zero code to a rejected code, then to a different accepted code, then to 000 and back. This separates the mismatch rule from the unequipped rule and shows that the two alarms hand over on the same frame. Bytes presented without the strobe, a clear written in the same cycle as a new status event, and a full counter wrap followed by one more count show the hold, set-priority and wrap behaviour.

// File: rtl/v5_mon_pkg.sv
package v5_mon_pkg;

    // V5 byte bit positions
    localparam int V5_RDI    = 0;
    localparam int V5_LBL_LO = 1;
    localparam int V5_RFI    = 4;
    localparam int V5_REI    = 5;

    // Status / enable bit indices
    localparam int SRC_UNEQ = 0;
    localparam int SRC_SLM  = 1;
    localparam int SRC_RFI  = 2;
    localparam int SRC_RDI  = 3;
    localparam int SRC_WRAP = 4;
    localparam int NSRC     = 5;

    // Filter instance indices
    localparam int FI_RDI  = 0;
    localparam int FI_SLM  = 1;
    localparam int FI_UNEQ = 2;
    localparam int NFILT   = 3;

    typedef enum logic [1:0] {
        ADDR_IE  = 2'd0,
        ADDR_ST  = 2'd1,
        ADDR_LVL = 2'd2,
        ADDR_RSV = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_ARMING,
        F_ACTIVE,
        F_DISARM
    } filt_state_e;

endpackage

// File: rtl/v5_persist_filter.sv
module v5_persist_filter
    import v5_mon_pkg::*;
#(
    parameter int PERSIST = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic cond,
    output logic alarm,
    output logic evt
);
    localparam int CW = $clog2(PERSIST + 1);
    localparam logic [CW-1:0] LAST = CW'(PERSIST - 1);

    filt_state_e state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic nxt_on;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (valid) begin
            unique case (state)
                F_IDLE: begin
                    if (cond) begin
                        nxt     = (PERSIST == 1) ? F_ACTIVE : F_ARMING;
                        cnt_nxt = (PERSIST == 1) ? '0 : CW'(1);
                    end
                end
                F_ARMING: begin
                    if (!cond) begin
                        nxt     = F_IDLE;
                        cnt_nxt = '0;
                    end else if (cnt == LAST) begin
                        nxt     = F_ACTIVE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                F_ACTIVE: begin
                    if (!cond) begin
                        nxt     = (PERSIST == 1) ? F_IDLE : F_DISARM;
                        cnt_nxt = (PERSIST == 1) ? '0 : CW'(1);
                    end
                end
                F_DISARM: begin
                    if (cond) begin
                        nxt     = F_ACTIVE;
                        cnt_nxt = '0;
                    end else if (cnt == LAST) begin
                        nxt     = F_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        alarm  = (state == F_ACTIVE) || (state == F_DISARM);
        nxt_on = (nxt == F_ACTIVE) || (nxt == F_DISARM);
        evt    = nxt_on != alarm;
    end

endmodule

// File: rtl/v5_rei_counter.sv
module v5_rei_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             wrap_evt,
    output logic             ovf_q
);
    assign wrap_evt = inc && (&count);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= wrap_evt;
            if (inc) begin
                count <= wrap_evt ? '0 : count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/v5_alarm_regs.sv
module v5_alarm_regs
    import v5_mon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [1:0]      addr,
    input  logic [7:0]      wdata,
    input  logic [NSRC-1:0] evt,
    input  logic [3:0]      levels,
    output logic [7:0]      rdata,
    output logic [NSRC-1:0] en,
    output logic            irq
);
    logic [NSRC-1:0] st;
    logic [NSRC-1:0] clr;
    reg_addr_e       a;

    assign a = reg_addr_e'(addr);

    always_comb begin
        clr = '0;
        if (wr && a == ADDR_ST) begin
            clr = wdata[NSRC-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
            en <= '0;
        end else begin
            st <= (st & ~clr) | evt;
            if (wr && a == ADDR_IE) begin
                en <= wdata[NSRC-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (a)
            ADDR_IE:  rdata[NSRC-1:0] = en;
            ADDR_ST:  rdata[NSRC-1:0] = st;
            ADDR_LVL: rdata[3:0]      = levels;
            ADDR_RSV: rdata           = '0;
        endcase
    end

    assign irq = |(st & en);

endmodule

// File: rtl/v5_alarm_mon.sv
module v5_alarm_mon
    import v5_mon_pkg::*;
#(
    parameter int PERSIST = 5,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v5_valid,
    input  logic [7:0]       v5_byte,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             alm_rdi,
    output logic             alm_rfi,
    output logic             alm_slm,
    output logic             alm_uneq,
    output logic [CNT_W-1:0] rei_count,
    output logic             rei_ovf,
    output logic             irq
);
    logic [2:0]       lbl;
    logic [NFILT-1:0] f_cond, f_alarm, f_evt;
    logic             rfi_q, rfi_evt, wrap_evt;
    logic [NSRC-1:0]  evt, irq_en;

    assign lbl = v5_byte[V5_LBL_LO +: 3];

    always_comb begin
        f_cond          = '0;
        f_cond[FI_RDI]  = v5_byte[V5_RDI];
        f_cond[FI_SLM]  = lbl > 3'd2;
        f_cond[FI_UNEQ] = lbl == 3'd0;
    end

    generate
        for (genvar g = 0; g < NFILT; g++) begin : g_filt
            v5_persist_filter #(.PERSIST(PERSIST)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .valid (v5_valid),
                .cond  (f_cond[g]),
                .alarm (f_alarm[g]),
                .evt   (f_evt[g])
            );
        end
    endgenerate

    // RFI follows each received indication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rfi_q <= 1'b0;
        end else if (v5_valid) begin
            rfi_q <= v5_byte[V5_RFI];
        end
    end
    assign rfi_evt = v5_valid && (v5_byte[V5_RFI] != rfi_q);

    v5_rei_counter #(.CNT_W(CNT_W)) u_rei (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (v5_valid && v5_byte[V5_REI]),
        .count    (rei_count),
        .wrap_evt (wrap_evt),
        .ovf_q    (rei_ovf)
    );

    always_comb begin
        evt           = '0;
        evt[SRC_UNEQ] = f_evt[FI_UNEQ];
        evt[SRC_SLM]  = f_evt[FI_SLM];
        evt[SRC_RFI]  = rfi_evt;
        evt[SRC_RDI]  = f_evt[FI_RDI];
        evt[SRC_WRAP] = wrap_evt;
    end

    assign alm_rdi  = f_alarm[FI_RDI];
    assign alm_slm  = f_alarm[FI_SLM];
    assign alm_uneq = f_alarm[FI_UNEQ];
    assign alm_rfi  = rfi_q;

    v5_alarm_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .evt    (evt),
        .levels ({alm_rdi, alm_rfi, alm_slm, alm_uneq}),
        .rdata  (reg_rdata),
        .en     (irq_en),
        .irq    (irq)
    );

endmodule

// File: rtl/v5_alarm_mon_chk.sv
module v5_alarm_mon_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             v5_valid,
    input logic [7:0]       v5_byte,
    input logic             alm_rdi,
    input logic             alm_rfi,
    input logic             alm_slm,
    input logic             alm_uneq,
    input logic [CNT_W-1:0] rei_count,
    input logic             rei_ovf,
    input logic             irq,
    input logic [4:0]       irq_en
);
    p_rdi_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_rdi) |-> ($past(v5_valid) && $past(v5_byte[0])));

    p_rfi_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v5_valid |=> (alm_rfi == $past(v5_byte[4])));

    p_slm_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_slm) |-> ($past(v5_byte[3:1]) > 3'd2));

    p_uneq_slm_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(alm_uneq && alm_slm));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v5_valid && v5_byte[5]) |=> (rei_count == CNT_W'($past(rei_count) + 1'b1)));

    p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rei_ovf |-> (rei_count == '0));

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !v5_valid |=> $stable({alm_rdi, alm_rfi, alm_slm, alm_uneq, rei_count}));

endmodule

bind v5_alarm_mon v5_alarm_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .v5_valid  (v5_valid),
    .v5_byte   (v5_byte),
    .alm_rdi   (alm_rdi),
    .alm_rfi   (alm_rfi),
    .alm_slm   (alm_slm),
    .alm_uneq  (alm_uneq),
    .rei_count (rei_count),
    .rei_ovf   (rei_ovf),
    .irq       (irq),
    .irq_en    (irq_en)
);

// File: tb/v5_alarm_mon_test.sv
module v5_alarm_mon_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v5_valid = 1'b0;
    logic [7:0]  v5_byte = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        alm_rdi, alm_rfi, alm_slm, alm_uneq, rei_ovf, irq;
    logic [15:0] rei_count;

    int total = 0;
    int fails = 0;
    string phase = "reset";

    // Reference state
    bit m_rdi, m_rfi, m_slm, m_uneq, m_ovf;
    int r_rdi, r_slm, r_uneq;
    int m_cnt;
    bit [4:0] m_st, m_en;

    always #10 clk = ~clk;

    v5_alarm_mon uut (
        .clk(clk), .rst_n(rst_n), .v5_valid(v5_valid), .v5_byte(v5_byte),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alm_rdi(alm_rdi), .alm_rfi(alm_rfi),
        .alm_slm(alm_slm), .alm_uneq(alm_uneq), .rei_count(rei_count),
        .rei_ovf(rei_ovf), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    task automatic filt(inout bit on, inout int run, input bit c, output bit e);
        e = 1'b0;
        if (c == on) run = 0;
        else begin
            run++;
            if (run == 5) begin
                on = c;
                run = 0;
                e = 1'b1;
            end
        end
    endtask

    function automatic int exp_rdata(input logic [1:0] a);
        case (a)
            2'd0: return int'(m_en);
            2'd1: return int'(m_st);
            2'd2: return int'({m_rdi, m_rfi, m_slm, m_uneq});
            default: return 0;
        endcase
    endfunction

    task automatic compare_all();
        check("R2 R3 rdi", int'(alm_rdi), int'(m_rdi));
        check("R4 rfi", int'(alm_rfi), int'(m_rfi));
        check("R5 R6 slm", int'(alm_slm), int'(m_slm));
        check("R7 uneq", int'(alm_uneq), int'(m_uneq));
        check("R8 count", int'(rei_count), m_cnt);
        check("R9 ovf", int'(rei_ovf), int'(m_ovf));
        check("R11 irq", int'(irq), int'(|(m_st & m_en)));
        check("R10 rdata", int'(reg_rdata), exp_rdata(reg_addr));
    endtask

    // Apply one cycle of stimulus; called at a negedge
    task automatic step(input bit vld, input logic [7:0] b, input bit wr,
                        input logic [1:0] a, input logic [7:0] wd);
        bit [4:0] ev;
        bit e;
        bit [4:0] clr;
        v5_valid = vld; v5_byte = b; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        ev = '0;
        m_ovf = 1'b0;
        if (vld) begin
            filt(m_rdi, r_rdi, b[0], e);            ev[3] = e;
            filt(m_slm, r_slm, b[3:1] > 3'd2, e);   ev[1] = e;
            filt(m_uneq, r_uneq, b[3:1] == 3'd0, e); ev[0] = e;
            if (b[4] != m_rfi) begin m_rfi = b[4]; ev[2] = 1'b1; end
            if (b[5]) begin
                if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1'b1; ev[4] = 1'b1; end
                else m_cnt++;
            end
        end
        clr = (wr && a == 2'd1) ? wd[4:0] : 5'd0;
        m_st = (m_st & ~clr) | ev;
        if (wr && a == 2'd0) m_en = wd[4:0];
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        v5_valid = 1'b0;
        compare_all();
    endtask

    task automatic frames(input int n, input logic [7:0] b);
        for (int i = 0; i < n; i++) step(1'b1, b, 1'b0, 2'd2, 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        phase = "R1 reset";
        compare_all();
        rst_n = 1'b1;
        step(1'b0, 8'h00, 1'b0, 2'd0, 8'h00);
        // R11 enables
        phase = "R11 enable all";
        step(1'b0, 8'h00, 1'b1, 2'd0, 8'h1F);
        step(1'b0, 8'h00, 1'b0, 2'd0, 8'h00);
        // settle label to accepted 001: UNEQ never set, status quiet
        phase = "baseline";
        frames(2, 8'h02);
        // R2 broken run
        phase = "R2 broken run";
        frames(4, 8'h03);
        frames(1, 8'h02);
        phase = "R2 full run";
        frames(5, 8'h03);
        // R12 idle bytes
        phase = "R12 idle frames";
        for (int i = 0; i < 6; i++) step(1'b0, 8'hFF - 8'(i), 1'b0, 2'd1, 8'h00);
        // R3 clear
        phase = "R3 broken run";
        frames(4, 8'h02);
        frames(1, 8'h03);
        phase = "R3 full run";
        frames(5, 8'h02);
        // R10 clear status via write-1
        phase = "R10 w1c";
        step(1'b0, 8'h00, 1'b1, 2'd1, 8'h1F);
        step(1'b0, 8'h00, 1'b0, 2'd1, 8'h00);
        // R4 RFI
        phase = "R4 rfi";
        frames(2, 8'h12);
        frames(1, 8'h02);
        // R5 SLM, R6 clear
        phase = "R5 slm";
        frames(4, 8'h0A);
        frames(1, 8'h02);
        frames(5, 8'h0E);
        phase = "R6 slm clear";
        frames(5, 8'h04);
        // R7 UNEQ
        phase = "R7 uneq";
        frames(5, 8'h00);
        frames(5, 8'h0A);
        frames(5, 8'h06);
        // R10 set wins over simultaneous clear, writes to addr 2/3 ignored
        phase = "R10 set priority";
        step(1'b0, 8'h00, 1'b1, 2'd1, 8'h1F);
        step(1'b1, 8'h16, 1'b1, 2'd1, 8'h04);
        step(1'b0, 8'h00, 1'b1, 2'd2, 8'hFF);
        step(1'b0, 8'h00, 1'b1, 2'd3, 8'hFF);
        step(1'b0, 8'h00, 1'b0, 2'd3, 8'h00);
        // R11 masking
        phase = "R11 mask";
        step(1'b0, 8'h00, 1'b1, 2'd0, 8'h01);
        step(1'b0, 8'h00, 1'b1, 2'd0, 8'h04);
        step(1'b0, 8'h00, 1'b1, 2'd1, 8'h1F);
        step(1'b0, 8'h00, 1'b1, 2'd0, 8'h10);
        // R8 counting with and without REI bit
        phase = "R8 count";
        frames(3, 8'h26);
        frames(2, 8'h06);
        // R9 wrap
        phase = "R9 wrap";
        while (m_cnt != 65535) step(1'b1, 8'h22, 1'b0, 2'd1, 8'h00);
        step(1'b1, 8'h22, 1'b0, 2'd1, 8'h00);
        step(1'b1, 8'h22, 1'b0, 2'd1, 8'h00);
        step(1'b0, 8'h00, 1'b0, 2'd1, 8'h00);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule